// File: doc/BRIEF.md
# Burst Address Low-Bit Sequencer

This block produces the low address bits that walk a synchronous memory through a four-word burst. When a new access starts, it captures the starting low bits. Each later step moves one beat through the four-word group. Two beat orders are supported: a linear order that adds the beat number to the start and wraps inside the group, and an interleaved order that XORs the beat number into the start. A static strap picks the order. The enclosing design keeps the upper address bits; this block only ever changes the bits inside the group.

Each control input is sampled on a rising clock edge, and only when the active-low clock enable is low. The single load/advance input is read as follows: low starts a new burst, and high steps the current burst forward. A deselect indication ends the burst. Once a deselect has been seen, a load must come before any step is accepted. A step requested while no burst is running is dropped, and this is reported on a one-cycle error output. Beats past the fourth wrap around within the same group.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, `addr_lsb`=0, `beat_cnt`=0 and `adv_err`=0. No burst is active after reset.
- R2: On an enabled edge (`clk_en_n`=0) with `deselect`=0 and `advance`=0, `start_lsb` is captured. From the next cycle `beat_cnt`=0 and `addr_lsb` equals the captured start.
- R3: With `order_mode`=0 (linear), `addr_lsb` = (start + `beat_cnt`) mod 4.
- R4: With `order_mode`=1 (interleaved), `addr_lsb` = start XOR `beat_cnt`.
- R5: On an enabled edge with `deselect`=0, `advance`=1 and a burst active, `beat_cnt` increments by one. From beat 3 it wraps to 0, so `addr_lsb` returns to the start.
- R6: On an edge with `clk_en_n`=1, `addr_lsb` and `beat_cnt` hold, whatever the other inputs are, and `adv_err` is 0 on the next cycle.
- R7: On an enabled edge with `deselect`=1, the burst ends and `addr_lsb` and `beat_cnt` hold. This holds even when `advance`=0 requests a load at the same edge.
- R8: On an enabled edge with `advance`=1 and `deselect`=0 while no burst is active, the step is ignored. `addr_lsb` and `beat_cnt` hold, and `adv_err` is 1 for exactly the next cycle. A later load restarts normal operation.
- R9: `adv_err` is 0 on the cycle after any edge that is not an ignored step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the sequencer |
| advance | input | 1 | 1 = step the burst, 0 = load a new start |
| deselect | input | 1 | Ends the current burst on an enabled edge |
| start_lsb | input | BEAT_W | Low address bits of a new access |
| order_mode | input | 1 | 0 = linear order, 1 = interleaved order (static) |
| addr_lsb | output | BEAT_W | Current low address bits |
| beat_cnt | output | BEAT_W | Beat number within the burst |
| adv_err | output | 1 | Pulses for one cycle after an ignored step |

## Verification
Every result follows one register stage. A load, step, hold or deselect sampled at one rising edge shows up on `beat_cnt`, `addr_lsb` and `adv_err` right after that edge, and stays there until the next edge. The exception is `order_mode`, which reaches `addr_lsb` combinationally. The driver applies inputs at the falling edge and queues the values expected after the next rising edge. The monitor takes each entry off the queue two nanoseconds after that rising edge and compares it there, so every comparison falls in the cycle in which the result is due.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_DROP  = 2'd1,
      CMD_START = 2'd2,
      CMD_STEP  = 2'd3
   } seq_cmd_e;

   typedef enum int {
      ORDER_STRAP      = 0,
      ORDER_LINEAR     = 1,
      ORDER_INTERLEAVE = 2
   } order_lock_e;

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
   import burst_seq_pkg::*;
(
   input  logic     clk_en_n,
   input  logic     advance,
   input  logic     deselect,
   output seq_cmd_e cmd
);

   always_comb begin
      if (clk_en_n)
         cmd = CMD_IDLE;
      else if (deselect)
         cmd = CMD_DROP;
      else if (!advance)
         cmd = CMD_START;
      else
         cmd = CMD_STEP;
   end

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
   import burst_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  seq_cmd_e cmd,
   output logic     active_q,
   output logic     err_q,
   output logic     step_ok
);

   assign step_ok = (cmd == CMD_STEP) && active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= (cmd == CMD_STEP) && !active_q;
         case (cmd)
            CMD_DROP:  active_q <= 1'b0;
            CMD_START: active_q <= 1'b1;
            default:   active_q <= active_q;
         endcase
      end
   end

endmodule

// File: rtl/bseq_counter.sv
module bseq_counter #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [BEAT_W-1:0] start_in,
   output logic [BEAT_W-1:0] start_q,
   output logic [BEAT_W-1:0] beat_q
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         beat_q  <= '0;
      end else if (load) begin
         start_q <= start_in;
         beat_q  <= '0;
      end else if (step) begin
         beat_q  <= beat_q + ONE;
      end
   end

endmodule

// File: rtl/bseq_order.sv
module bseq_order
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W     = 2,
   parameter int ORDER_LOCK = ORDER_STRAP
) (
   input  logic              mode,
   input  logic [BEAT_W-1:0] start_q,
   input  logic [BEAT_W-1:0] beat_q,
   output logic [BEAT_W-1:0] addr
);

   logic [BEAT_W-1:0] lin_addr;
   logic [BEAT_W-1:0] xor_addr;

   assign lin_addr = start_q + beat_q;
   assign xor_addr = start_q ^ beat_q;

   generate
      if (ORDER_LOCK == ORDER_LINEAR) begin : g_lin
         assign addr = lin_addr;
      end else if (ORDER_LOCK == ORDER_INTERLEAVE) begin : g_xor
         assign addr = xor_addr;
      end else begin : g_strap
         assign addr = mode ? xor_addr : lin_addr;
      end
   endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W     = 2,
   parameter int ORDER_LOCK = ORDER_STRAP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_n,
   input  logic              advance,
   input  logic              deselect,
   input  logic [BEAT_W-1:0] start_lsb,
   input  logic              order_mode,
   output logic [BEAT_W-1:0] addr_lsb,
   output logic [BEAT_W-1:0] beat_cnt,
   output logic              adv_err
);

   localparam int BEATS = 1 << BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_width
         $error("burst_addr_seq: BEAT_W must be 1..8");
      end
      if (ORDER_LOCK < ORDER_STRAP || ORDER_LOCK > ORDER_INTERLEAVE) begin : g_bad_lock
         $error("burst_addr_seq: ORDER_LOCK out of range");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("burst_addr_seq: burst needs at least two beats");
      end
   endgenerate

   seq_cmd_e          cmd;
   logic              active_q;
   logic              step_ok;
   logic              load;
   logic [BEAT_W-1:0] start_q;

   assign load = (cmd == CMD_START);

   bseq_decode u_dec (
      .clk_en_n (clk_en_n),
      .advance  (advance),
      .deselect (deselect),
      .cmd      (cmd)
   );

   bseq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .active_q (active_q),
      .err_q    (adv_err),
      .step_ok  (step_ok)
   );

   bseq_counter #(.BEAT_W(BEAT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .step     (step_ok),
      .start_in (start_lsb),
      .start_q  (start_q),
      .beat_q   (beat_cnt)
   );

   bseq_order #(.BEAT_W(BEAT_W), .ORDER_LOCK(ORDER_LOCK)) u_ord (
      .mode    (order_mode),
      .start_q (start_q),
      .beat_q  (beat_cnt),
      .addr    (addr_lsb)
   );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              advance,
   input logic              deselect,
   input logic [BEAT_W-1:0] start_lsb,
   input logic              order_mode,
   input logic [BEAT_W-1:0] addr_lsb,
   input logic [BEAT_W-1:0] beat_cnt,
   input logic              adv_err,
   input logic              active
);

   logic en_start;
   logic en_step_ok;
   logic en_step_bad;

   assign en_start    = !clk_en_n && !deselect && !advance;
   assign en_step_ok  = !clk_en_n && !deselect && advance && active;
   assign en_step_bad = !clk_en_n && !deselect && advance && !active;

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_start |=> (beat_cnt == '0) && (addr_lsb == $past(start_lsb)) && active);

   // R3
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_step_ok && !order_mode) |=>
         (order_mode || (addr_lsb == BEAT_W'($past(addr_lsb) + BEAT_W'(1)))));

   // R4
   xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_step_ok && order_mode) |=>
         (!order_mode || ((addr_lsb ^ $past(addr_lsb)) == (beat_cnt ^ $past(beat_cnt)))));

   // R5
   beat_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_step_ok |=> (beat_cnt == BEAT_W'($past(beat_cnt) + BEAT_W'(1))));

   // R6
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(beat_cnt) && !adv_err);

   // R7
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && deselect) |=> !active && $stable(beat_cnt) && !adv_err);

   // R8
   bad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_step_bad |=> adv_err && $stable(beat_cnt));

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_step_bad |=> !adv_err);

endmodule

bind burst_addr_seq bseq_chk #(.BEAT_W(BEAT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en_n   (clk_en_n),
   .advance    (advance),
   .deselect   (deselect),
   .start_lsb  (start_lsb),
   .order_mode (order_mode),
   .addr_lsb   (addr_lsb),
   .beat_cnt   (beat_cnt),
   .adv_err    (adv_err),
   .active     (active_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en_n = 1'b1;
   logic       advance = 1'b0;
   logic       deselect = 1'b0;
   logic [1:0] start_lsb = 2'd0;
   logic       order_mode = 1'b0;
   wire  [1:0] addr_lsb;
   wire  [1:0] beat_cnt;
   wire        adv_err;

   always #4 clk = ~clk;

   burst_addr_seq u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en_n   (clk_en_n),
      .advance    (advance),
      .deselect   (deselect),
      .start_lsb  (start_lsb),
      .order_mode (order_mode),
      .addr_lsb   (addr_lsb),
      .beat_cnt   (beat_cnt),
      .adv_err    (adv_err)
   );

   typedef struct {
      logic [1:0] a;
      logic [1:0] b;
      logic       e;
      string      tag;
   } exp_t;

   exp_t sbq[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;

   logic [1:0] m_start = 2'd0;
   logic [1:0] m_beat = 2'd0;
   logic       m_act = 1'b0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // driver: apply at falling edge, queue the values due after the next rising edge
   task automatic step(input logic en_n, input logic adv, input logic des,
                       input logic [1:0] s, input logic md, input string tag);
      exp_t x;
      logic e;
      @(negedge clk);
      clk_en_n   = en_n;
      advance    = adv;
      deselect   = des;
      start_lsb  = s;
      order_mode = md;
      e = 1'b0;
      if (!en_n) begin
         if (des) m_act = 1'b0;
         else if (!adv) begin
            m_start = s;
            m_beat  = 2'd0;
            m_act   = 1'b1;
         end else if (m_act) m_beat = m_beat + 2'd1;
         else e = 1'b1;
      end
      x.a   = md ? (m_start ^ m_beat) : (m_start + m_beat);
      x.b   = m_beat;
      x.e   = e;
      x.tag = tag;
      sbq.push_back(x);
   endtask

   // monitor
   always @(posedge clk) begin
      exp_t x;
      #2;
      if (sbq.size() > 0) begin
         x = sbq.pop_front();
         chk(x.tag, "addr_lsb", 32'(addr_lsb), 32'(x.a));
         chk(x.tag, "beat_cnt", 32'(beat_cnt), 32'(x.b));
         chk(x.tag, "adv_err",  32'(adv_err),  32'(x.e));
      end
   end

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "addr_lsb in reset", 32'(addr_lsb), 0);
      chk("R1", "beat_cnt in reset", 32'(beat_cnt), 0);
      chk("R1", "adv_err in reset",  32'(adv_err),  0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "addr_lsb after reset", 32'(addr_lsb), 0);
      chk("R1", "beat_cnt after reset", 32'(beat_cnt), 0);

      // R1 / R8: no burst after reset, a step is flagged
      step(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, "R8");
      step(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R9");
      // R2 + R3 linear from 2: 2,3,0,1 then wrap R5
      step(1'b0, 1'b0, 1'b0, 2'd2, 1'b0, "R2");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3");
      step(1'b0, 1'b1, 1'b0, 2'd1, 1'b0, "R3");
      step(1'b0, 1'b1, 1'b0, 2'd1, 1'b0, "R3");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R5");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R5");
      // R6: enable high freezes everything
      step(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, "R6");
      step(1'b1, 1'b1, 1'b1, 2'd3, 1'b0, "R6");
      step(1'b1, 1'b1, 1'b0, 2'd2, 1'b0, "R6");
      // R4 interleaved from 1: 1,0,3,2 then wrap
      step(1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R2");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R5");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      // R7: deselect wins over a load request
      step(1'b0, 1'b0, 1'b1, 2'd3, 1'b1, "R7");
      step(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R8");
      step(1'b0, 1'b1, 1'b0, 2'd3, 1'b1, "R8");
      step(1'b1, 1'b1, 1'b0, 2'd3, 1'b1, "R9");
      // R8: a load restarts after the ignored steps; interleaved from 2
      step(1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R8");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b1, "R4");
      // linear from 3 with a hold in the middle
      step(1'b0, 1'b0, 1'b0, 2'd3, 1'b0, "R2");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3");
      step(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, "R6");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R3");
      step(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, "R5");
      step(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, "R7");
      step(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R9");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule